// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a free-running 8-bit interval timer for a small microcontroller. A 9-bit prescaler divides the system clock. A rate bit in a 4-bit mode register chooses which prescaler tap advances the counter: divide by 32 or divide by 512. The counter never stops. Each time it wraps from 0xFF to 0x00 it raises an interrupt request, and that request stays asserted until software clears it.

Software can read the live count at any moment, so it can time short waits such as an oscillator settling delay. It can also restart the count from zero by writing the mode register with the restart bit set. The register port is a one-bit address with a synchronous write strobe and a combinational read path. Address 0 selects the mode register and address 1 selects the counter.

Top module: `ivt_timer`

## Requirements
- R1: The 8-bit counter advances by exactly one on every prescaler tick, has no enable, and wraps from 0xFF to 0x00.
- R2: Mode bit 0 picks the rate. With bit 0 = 1 the counter advances once every 32 clocks. With bit 0 = 0 it advances once every 512 clocks. The first advance after a restart comes at the 32nd (or 512th) rising edge.
- R3: `irq_o` goes high at the clock edge where the counter wraps. After a restart the first request is therefore due 256 × prescale clocks later, which is 8192 clocks at the fast rate.
- R4: Once set, `irq_o` stays high until `irq_clr` is high at a clock edge. If a wrap and a clear fall on the same edge, the flag ends up set.
- R5: A mode write with bit 1 = 1 zeroes both the prescaler and the counter at that edge, and counting resumes from zero. If the restart coincides with a wrap, no request is raised.
- R6: Every mode write loads the whole 4-bit value, and bit 0 takes effect from that write. A read at address 0 returns the rate bit in bit 0. The restart bit and all other bits read as 0.
- R7: A read at address 1 returns the live counter value on `reg_rdata` in the same cycle.
- R8: Writes to address 1 are ignored; the counter keeps its sequence.
- R9: A mode write that changes the rate without the restart bit does not disturb the prescaler or the counter. The new tap applies from the next edge.
- R10: Synchronous active-low reset clears the counter, the prescaler, the mode register and `irq_o`. After reset the timer runs at the slow rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 1 | Register select: 0 mode, 1 counter |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 4 | Write data for the mode register |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| irq_clr | input | 1 | Clears the interrupt request flag |
| irq_o | output | 1 | Interrupt request flag |

## Verification
A restart written at edge E puts the counter at zero right after E. The counter then reads floor(k / prescale) mod 256 after k further edges, and `irq_o` is high once k reaches 256 × prescale. The bench records the cycle number at the negative edge after each restart and samples only at later negative edges, so every expected count and flag value comes from the elapsed edge count alone. Read data is combinational, so it is sampled 1 ns after the address is set within the same low phase. The effects of a flag clear and of a rate change are checked at the first negative edge after the write edge, and again after later edges.

// File: rtl/ivt_pkg.sv
// Shared constants for the prescaled interval timer.
// Assumes a one-bit register address and a 4-bit mode register.
package ivt_pkg;
    localparam int MODE_W      = 4;
    localparam int RATE_BIT    = 0;
    localparam int RESTART_BIT = 1;

    typedef enum logic {
        ADDR_MODE  = 1'b0,
        ADDR_COUNT = 1'b1
    } ivt_addr_e;
endpackage

// File: rtl/ivt_prescaler.sv
// Free-running clock divider with two taps.
// Emits a one-cycle tick when the low FAST_LOG2 or SLOW_LOG2 bits are all ones,
// so a tick occurs every 2**FAST_LOG2 or 2**SLOW_LOG2 clocks.
// Assumes SLOW_LOG2 > FAST_LOG2 >= 1. A clear returns the divider to zero.
module ivt_prescaler #(
    parameter int FAST_LOG2 = 5,
    parameter int SLOW_LOG2 = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fast,
    output logic tick
);
    localparam int PRE_W  = SLOW_LOG2;
    localparam int N_TAPS = 2;

    logic [PRE_W-1:0]  pre_q;
    logic [N_TAPS-1:0] tap_hit;

    // Divider register: counts every clock, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)   pre_q <= '0;
        else if (clr) pre_q <= '0;
        else          pre_q <= pre_q + 1'b1;
    end

    // One all-ones detector per tap; index 0 is the slow tap, 1 the fast tap.
    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int TAP_W = (i == 0) ? SLOW_LOG2 : FAST_LOG2;
        assign tap_hit[i] = &pre_q[TAP_W-1:0];
    end

    // Tap selection by the rate bit.
    always_comb tick = fast ? tap_hit[1] : tap_hit[0];
endmodule

// File: rtl/ivt_counter.sv
// Interval counter advanced by prescaler ticks, with no enable.
// Reports a wrap from all ones to zero; a restart overrides both the
// increment and the wrap report.
module ivt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: zeroed by restart, else stepped on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // Wrap event: the tick that carries the counter out of its top value.
    always_comb wrap = tick && (cnt_q == {CNT_W{1'b1}}) && !clr;

    assign cnt = cnt_q;
endmodule

// File: rtl/ivt_mode_reg.sv
// Mode register write decoder.
// Holds the rate bit and turns a write that has the restart bit set into
// a one-cycle restart pulse. Only whole-register writes exist.
module ivt_mode_reg
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [MODE_W-1:0] reg_wdata,
    output logic              fast,
    output logic              restart
);
    logic mode_sel;
    logic rate_q;

    // Decode a write aimed at the mode register.
    always_comb mode_sel = reg_wr && (reg_addr == ADDR_MODE);

    // Rate bit storage, reloaded on every mode write.
    always_ff @(posedge clk) begin
        if (!rst_n)        rate_q <= 1'b0;
        else if (mode_sel) rate_q <= reg_wdata[RATE_BIT];
    end

    // Restart request; it is never stored, so it reads back as zero.
    always_comb restart = mode_sel && reg_wdata[RESTART_BIT];

    assign fast = rate_q;
endmodule

// File: rtl/ivt_irq_flag.sv
// Sticky interrupt request flag.
// A set wins over a clear that arrives in the same cycle.
module ivt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/ivt_timer.sv
// Prescaled interval timer, top level.
// Joins the divider, the counter, the mode register and the request flag,
// and provides the combinational read path for both registers.
// Assumes CNT_W >= 2.
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int FAST_LOG2 = 5,
    parameter int SLOW_LOG2 = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [MODE_W-1:0] reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              irq_clr,
    output logic              irq_o
);
    logic             fast;
    logic             restart;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt_q;

    ivt_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .fast      (fast),
        .restart   (restart)
    );

    ivt_prescaler #(
        .FAST_LOG2 (FAST_LOG2),
        .SLOW_LOG2 (SLOW_LOG2)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .fast  (fast),
        .tick  (tick)
    );

    ivt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .tick  (tick),
        .cnt   (cnt_q),
        .wrap  (wrap)
    );

    ivt_irq_flag u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wrap),
        .clr   (irq_clr),
        .flag  (irq_o)
    );

    // Read path: live count, or the rate bit with every other bit zero.
    always_comb begin
        if (reg_addr == ADDR_COUNT) reg_rdata = cnt_q;
        else                        reg_rdata = {{(CNT_W-1){1'b0}}, fast};
    end
endmodule

// File: rtl/ivt_timer_chk.sv
// Assertion checker for the interval timer, bound to the top module.
module ivt_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic             irq_clr,
    input logic             restart,
    input logic             reg_addr,
    input logic [CNT_W-1:0] reg_rdata
);
    // R1: the count only steps by one or returns to zero.
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

    // R3: the request rises only on a wrap from the top value.
    p_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (($past(cnt) == {CNT_W{1'b1}}) && (cnt == '0)));

    // R4: the request holds while no clear is applied.
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R5: a restart zeroes the count and raises no request.
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !irq_clr) |=> ((cnt == '0) && $stable(irq)));

    // R6: the mode view carries nothing above the rate bit.
    p_modeview_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b0) |-> (reg_rdata[CNT_W-1:1] == '0));
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_q),
    .irq       (irq_o),
    .irq_clr   (irq_clr),
    .restart   (restart),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/ivt_timer_tb_top.sv
`timescale 1ns/1ps
module ivt_timer_tb_top;
    localparam int FAST_DIV = 32;
    localparam int SLOW_DIV = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_wdata = 4'h0;
    logic [7:0] reg_rdata;
    logic       irq_clr = 1'b0;
    logic       irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int t0     = 0;
    bit rate_fast = 1'b0;

    ivt_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_clr   (irq_clr),
        .irq_o     (irq_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_cnt(int el, bit f);
        return (el / (f ? FAST_DIV : SLOW_DIV)) % 256;
    endfunction

    function automatic int exp_irq(int el, bit f);
        return (el >= 256 * (f ? FAST_DIV : SLOW_DIV)) ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr(input logic a, input logic [3:0] d, input logic clr);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d; irq_clr = clr;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic restart(bit f);
        wr(1'b0, {2'b00, 1'b1, f}, 1'b1);
        t0 = cyc;
        rate_fast = f;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic chk_all(string req);
        int v;
        rd(1'b1, v);
        chk({req, " count"}, v, exp_cnt(cyc - t0, rate_fast));
        chk({req, " irq"}, int'(irq_o), exp_irq(cyc - t0, rate_fast));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'h5EED));
        // R10: reset state and slow default rate.
        wait_n(5);
        rd(1'b1, v); chk("R10 count in reset", v, 0);
        rd(1'b0, v); chk("R10 mode in reset", v, 0);
        chk("R10 irq in reset", int'(irq_o), 0);
        rst_n = 1'b1;
        t0 = cyc; rate_fast = 1'b0;
        wait_n(3 * SLOW_DIV + 5);
        chk_all("R10 R2 slow default");

        // R2, R7: fast rate, first step on the 32nd edge.
        restart(1'b1);
        chk_all("R5 restart zero");
        wait_n(31); chk_all("R2 before first step");
        wait_n(1);  chk_all("R2 first step");
        rd(1'b0, v); chk("R6 mode readback", v, 1);

        // R8: a counter write is ignored.
        wr(1'b1, 4'hF, 1'b0);
        chk_all("R8 count write ignored");
        wait_n(40); chk_all("R8 count continues");

        // R3, R4, R1: overflow, priority over clear, sticky, wrap.
        restart(1'b1);
        wait_n(256 * FAST_DIV - 1);
        chk_all("R3 just before wrap");
        pulse_clr();
        chk("R4 set wins over clear", int'(irq_o), 1);
        rd(1'b1, v); chk("R1 wrap to zero", v, 0);
        wait_n(500);
        chk("R4 flag sticky", int'(irq_o), 1);
        rd(1'b1, v); chk("R1 count after wrap", v, exp_cnt(cyc - t0, 1'b1));
        pulse_clr();
        chk("R4 clear", int'(irq_o), 0);

        // R5: a restart on the wrap edge suppresses the request.
        restart(1'b1);
        wait_n(256 * FAST_DIV - 1);
        restart(1'b1);
        chk_all("R5 restart at wrap");
        wait_n(40); chk_all("R5 count resumes");

        // R9: rate change without restart keeps the divider phase.
        restart(1'b1);
        wait_n(100);
        wr(1'b0, 4'b0000, 1'b0);
        wait_n(410);
        rd(1'b1, v); chk("R9 rate switch hold", v, 3);
        wait_n(1);
        rd(1'b1, v); chk("R9 rate switch step", v, 4);
        rd(1'b0, v); chk("R6 slow readback", v, 0);

        // Random trials.
        for (int t = 0; t < 12; t++) begin
            bit f;
            f = 1'($urandom % 2);
            restart(f);
            for (int k = 0; k < 4; k++) begin
                int n;
                int sel;
                n = $urandom_range(1, 1500);
                wait_n(n);
                sel = $urandom % 3;
                if (sel == 0) wr(1'b1, 4'($urandom), 1'b0);
                else if (sel == 1) wr(1'b0, {2'($urandom), 1'b0, f}, 1'b0);
                chk_all("R1 R2 R8 random");
                rd(1'b0, v); chk("R6 random mode", v, int'(f));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule